// File: doc/BRIEF.md
# SPI Host Transaction Engine with Programmable Byte Gaps

This block is an SPI host (clock idle low, data launched on the falling edge and captured on the rising edge). It runs in the system clock domain and carries out single register writes and reads, burst accesses, command strobes and FIFO transfers with a slave transceiver. A command names the direction, the burst flag, a 6-bit address, a data byte count and whether the slave is currently asleep. The engine sends a header byte, then the data bytes. It pulls write bytes by index and returns read bytes one at a time. It also keeps the status byte that the slave shifts out while the header is being sent.

Every timing limit is given as a parameter in nanoseconds and is rounded up to whole system clock cycles. These limits are the SCLK half period, the pause after the header and between data bytes, the wait from chip select to the first edge (short when the slave is awake, long when it is asleep) and the delay before chip select is released. The programmable pause lets SCLK run at its top rate, because the slave gets its recovery time between bytes rather than through a slower clock.

Top module: `spi_burst_host`

## Requirements
- R1: The first byte of every frame is the header: bit 7 is the read flag, bit 6 the burst flag and bits 5:0 the address. Each byte is sent most significant bit first.
- R2: A frame has exactly 8 × (1 + cmd_len) rising SCLK edges. Write data byte k (counting from 0) is the value on wr_data while wr_idx equals k.
- R3: In a read, SI is zero during the data bytes. Each data byte is assembled from SO sampled at the rising edges, MSB first. It is presented on rd_data with a one-cycle rd_valid pulse, in order, once per data byte, in the cycle SCLK falls after its last bit.
- R4: The byte received on SO during the header appears on status once the header ends, and stays there until the next header.
- R5: Inside a byte, SCLK is high for exactly HALF and low for exactly HALF system cycles, where HALF = ceil(HALF_NS/CLK_NS). SI does not change while SCLK is high.
- R6: Before the first rising edge of every byte after the header, SCLK stays low for GAP + HALF cycles, where GAP = ceil(GAP_NS/CLK_NS).
- R7: After CSn falls, the first rising SCLK edge comes SETUP + HALF cycles later. SETUP is ceil(SETUP_NS/CLK_NS) when cmd_pwrdn is 0 and ceil(PD_SETUP_NS/CLK_NS) when it is 1.
- R8: CSn rises ceil(HOLD_NS/CLK_NS) cycles after the last falling SCLK edge. SCLK is low whenever CSn is high.
- R9: cmd_ready is high only while the engine is idle, and busy is its inverse. A command presented while busy has no effect. done is a single-cycle pulse in the cycle CSn returns high.
- R10: After reset, CSn is high, SCLK is low, cmd_ready is high, and busy and done are low.
- R11: A command with cmd_len = 0 (a strobe) sends only the header byte, and then releases CSn after the tail delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command is taken this cycle |
| cmd_read | input | 1 | Header read flag |
| cmd_burst | input | 1 | Header burst flag |
| cmd_addr | input | 6 | Register or FIFO address |
| cmd_len | input | LEN_W | Number of data bytes after the header (0 = strobe) |
| cmd_pwrdn | input | 1 | Slave asleep: use the long lead-in wait |
| wr_data | input | 8 | Write byte for index wr_idx |
| wr_idx | output | LEN_W | Index of the next write byte to be loaded |
| rd_valid | output | 1 | rd_data holds a new read byte |
| rd_data | output | 8 | Received data byte |
| status | output | 8 | Byte received during the last header |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Pulse when CSn is released |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| si | output | 1 | Serial data to the slave |
| so | input | 1 | Serial data from the slave |

## Verification
The embedded properties check the following on every cycle: the length of each SCLK high phase, that SI is steady while SCLK is high, that SCLK is low with chip select released, that cmd_ready only appears with the bus quiet, and how done and rd_valid line up with the CSn and SCLK edges. The directed scenarios are the only place where the following can be seen: the header and data bit content, the length of each low interval (lead-in, inter-byte pause, in-byte half period), the tail delay, the status and read byte values, and that a command held during a transfer is ignored. These quantities depend on a whole frame rather than on one cycle.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

   localparam int ADDR_W = 6;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_BIT,
      ST_GAP,
      ST_TAIL
   } host_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int at_least_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_burst_timer.sv
module spi_burst_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);

   logic [W-1:0] cnt;

   assign zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= val;
      else if (!zero)  cnt <= cnt - W'(1);
   end

endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         sample,
   input  logic         din,
   output logic         dout,
   output logic [W-1:0] rx
);

   logic [W-1:0] tx;

   assign dout = tx[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx <= '0;
         rx <= '0;
      end else begin
         if (load)       tx <= load_val;
         else if (shift) tx <= {tx[W-2:0], 1'b0};
         if (sample)     rx <= {rx[W-2:0], din};
      end
   end

endmodule

// File: rtl/spi_burst_host.sv
module spi_burst_host
   import spi_burst_pkg::*;
#(
   parameter int CLK_NS      = 20,
   parameter int HALF_NS     = 50,
   parameter int GAP_NS      = 100,
   parameter int SETUP_NS    = 20,
   parameter int PD_SETUP_NS = 200000,
   parameter int HOLD_NS     = 20,
   parameter int LEN_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_read,
   input  logic              cmd_burst,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_pwrdn,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [LEN_W-1:0]  wr_idx,
   output logic              rd_valid,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] status,
   output logic              busy,
   output logic              done,
   output logic              cs_n,
   output logic              sclk,
   output logic              si,
   input  logic              so
);

   localparam int HALF_CYC  = at_least_one(ceil_div(HALF_NS, CLK_NS));
   localparam int GAP_CYC   = ceil_div(GAP_NS, CLK_NS);
   localparam int SETUP_CYC = at_least_one(ceil_div(SETUP_NS, CLK_NS));
   localparam int PD_CYC    = at_least_one(ceil_div(PD_SETUP_NS, CLK_NS));
   localparam int HOLD_CYC  = at_least_one(ceil_div(HOLD_NS, CLK_NS));
   localparam int LOAD_MAX  = max_int(max_int(PD_CYC, SETUP_CYC),
                                      max_int(max_int(HALF_CYC, GAP_CYC), HOLD_CYC));
   localparam int TW        = $clog2(LOAD_MAX + 1) + 1;

   localparam logic [TW-1:0] L_HALF  = TW'(HALF_CYC - 1);
   localparam logic [TW-1:0] L_SETUP = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] L_PD    = TW'(PD_CYC - 1);
   localparam logic [TW-1:0] L_HOLD  = TW'(HOLD_CYC - 1);

   // elaboration-time parameter checks
   generate
      if (CLK_NS < 1 || HALF_NS < 1 || GAP_NS < 0 || SETUP_NS < 0 || PD_SETUP_NS < 0 || HOLD_NS < 0) begin : g_bad_timing
         $error("spi_burst_host: timing parameters out of range");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("spi_burst_host: LEN_W must be 1..16");
      end
   endgenerate

   host_state_e       state, nxt;
   logic              sclk_q, cs_q, hdr_q, rd_q;
   logic [2:0]        bit_cnt;
   logic [LEN_W-1:0]  left, idx;
   logic [BYTE_W-1:0] status_q, rd_data_q;
   logic              rd_valid_q, done_q;

   logic              tmr_load, tmr_zero;
   logic [TW-1:0]     tmr_val;
   logic              sh_load;
   logic [BYTE_W-1:0] sh_val, rx_byte;
   logic              ev_accept, ev_rise, ev_fall, byte_end, ev_release;

   // where a finished byte goes next: pause state or straight into the next byte
   host_state_e   after_st;
   logic [TW-1:0] after_ld;
   generate
      if (GAP_CYC == 0) begin : g_nogap
         assign after_st = ST_BIT;
         assign after_ld = L_HALF;
      end else begin : g_gap
         assign after_st = ST_GAP;
         assign after_ld = TW'(GAP_CYC - 1);
      end
   endgenerate

   spi_burst_timer #(.W(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .val   (tmr_val),
      .zero  (tmr_zero)
   );

   spi_burst_shifter #(.W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (ev_fall),
      .sample   (ev_rise),
      .din      (so),
      .dout     (si),
      .rx       (rx_byte)
   );

   always_comb begin
      nxt        = state;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      sh_load    = 1'b0;
      sh_val     = '0;
      ev_accept  = 1'b0;
      ev_rise    = 1'b0;
      ev_fall    = 1'b0;
      byte_end   = 1'b0;
      ev_release = 1'b0;
      unique case (state)
         ST_IDLE: if (cmd_valid) begin
            ev_accept = 1'b1;
            nxt       = ST_LEAD;
            tmr_load  = 1'b1;
            tmr_val   = cmd_pwrdn ? L_PD : L_SETUP;
            sh_load   = 1'b1;
            sh_val    = {cmd_read, cmd_burst, cmd_addr};
         end
         ST_LEAD, ST_GAP: if (tmr_zero) begin
            nxt      = ST_BIT;
            tmr_load = 1'b1;
            tmr_val  = L_HALF;
         end
         ST_BIT: if (tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = L_HALF;
            if (!sclk_q) begin
               ev_rise = 1'b1;
            end else begin
               ev_fall = 1'b1;
               if (bit_cnt == 3'd7) begin
                  byte_end = 1'b1;
                  if (left != '0) begin
                     sh_load = 1'b1;
                     sh_val  = rd_q ? '0 : wr_data;
                     nxt     = after_st;
                     tmr_val = after_ld;
                  end else begin
                     nxt     = ST_TAIL;
                     tmr_val = L_HOLD;
                  end
               end
            end
         end
         ST_TAIL: if (tmr_zero) begin
            ev_release = 1'b1;
            nxt        = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sclk_q     <= 1'b0;
         cs_q       <= 1'b1;
         hdr_q      <= 1'b0;
         rd_q       <= 1'b0;
         bit_cnt    <= '0;
         left       <= '0;
         idx        <= '0;
         status_q   <= '0;
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         state      <= nxt;
         rd_valid_q <= 1'b0;
         done_q     <= 1'b0;
         if (ev_accept) begin
            cs_q    <= 1'b0;
            left    <= cmd_len;
            idx     <= '0;
            hdr_q   <= 1'b1;
            rd_q    <= cmd_read;
            bit_cnt <= '0;
         end
         if (ev_rise) sclk_q <= 1'b1;
         if (ev_fall) begin
            sclk_q  <= 1'b0;
            bit_cnt <= bit_cnt + 3'd1;
         end
         if (byte_end) begin
            hdr_q <= 1'b0;
            if (hdr_q) begin
               status_q <= rx_byte;
            end else if (rd_q) begin
               rd_data_q  <= rx_byte;
               rd_valid_q <= 1'b1;
            end
            if (left != '0) begin
               left <= left - LEN_W'(1);
               idx  <= idx + LEN_W'(1);
            end
         end
         if (ev_release) begin
            cs_q   <= 1'b1;
            done_q <= 1'b1;
         end
      end
   end

   assign cmd_ready = (state == ST_IDLE);
   assign busy      = ~cmd_ready;
   assign cs_n      = cs_q;
   assign sclk      = sclk_q;
   assign wr_idx    = idx;
   assign rd_valid  = rd_valid_q;
   assign rd_data   = rd_data_q;
   assign status    = status_q;
   assign done      = done_q;

   // ---------------- embedded properties ----------------
   logic [TW-1:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hi_run <= '0;
      else if (sclk) hi_run <= hi_run + TW'(1);
      else           hi_run <= '0;
   end

   // R5: every high phase lasts exactly HALF cycles
   p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> hi_run == TW'(HALF_CYC));

   // R5: SI is held while SCLK is high
   p_si_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(si));

   // R8: clock stays low while deselected
   p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R9: a command is only taken with the bus quiet
   p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (cs_n && !sclk));

   // R9: done marks the release of chip select
   p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !$past(cs_n)));

   // R3: read byte follows a falling edge
   p_rd_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (!sclk && $past(sclk)));

endmodule

// File: tb/spi_burst_host_test.sv
module spi_burst_host_test;

   localparam int CLK_NS  = 20;
   localparam int B_HALF  = (50 + CLK_NS - 1) / CLK_NS;
   localparam int B_GAP   = (100 + CLK_NS - 1) / CLK_NS;
   localparam int B_SETUP = (20 + CLK_NS - 1) / CLK_NS;
   localparam int B_PD    = (200000 + CLK_NS - 1) / CLK_NS;
   localparam int B_HOLD  = (20 + CLK_NS - 1) / CLK_NS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic       cmd_read = 1'b0;
   logic       cmd_burst = 1'b0;
   logic [5:0] cmd_addr = '0;
   logic [5:0] cmd_len = '0;
   logic       cmd_pwrdn = 1'b0;
   logic [7:0] wr_data;
   logic [5:0] wr_idx;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic [7:0] status;
   logic       busy, done, cs_n, sclk, si;
   logic       so = 1'b0;

   logic [7:0] wr_pat = 8'h00;
   logic [7:0] stat_byte = 8'hA5;

   assign wr_data = wr_pat ^ {2'b00, wr_idx};

   spi_burst_host uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_read(cmd_read), .cmd_burst(cmd_burst), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .cmd_pwrdn(cmd_pwrdn),
      .wr_data(wr_data), .wr_idx(wr_idx),
      .rd_valid(rd_valid), .rd_data(rd_data), .status(status),
      .busy(busy), .done(done),
      .cs_n(cs_n), .sclk(sclk), .si(si), .so(so)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- slave model and bus monitor ----------------
   int         frames = 0, rises = 0, mbits = 0;
   int         lo_cnt = 0, hi_cnt = 0, hi_min = 0, hi_max = 0, tail = 0;
   int         lo_run [0:511];
   logic [7:0] mo [0:63];
   logic [7:0] mcur = 8'h00;
   logic [7:0] rd_got [0:63];
   int         rd_n = 0;
   logic       prev_cs = 1'b1, prev_sclk = 1'b0;

   function automatic logic resp_bit(input int b);
      logic [7:0] v;
      v = (b / 8 == 0) ? stat_byte : (8'h3C ^ 8'(b / 8));
      return v[7 - (b % 8)];
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) begin
            rd_got[rd_n] = rd_data;
            rd_n++;
         end
         if (!cs_n) begin
            if (prev_cs) begin
               frames++;
               rises  = 0;
               mbits  = 0;
               hi_min = 9999;
               hi_max = 0;
               lo_cnt = 0;
               hi_cnt = 0;
               so     = resp_bit(0);
            end
            if (sclk) begin
               if (!prev_sclk) begin
                  lo_run[rises] = lo_cnt;
                  rises++;
                  mcur = {mcur[6:0], si};
                  mbits++;
                  if (mbits % 8 == 0) mo[mbits/8 - 1] = mcur;
                  hi_cnt = 0;
               end
               hi_cnt++;
            end else begin
               if (prev_sclk) begin
                  if (hi_cnt < hi_min) hi_min = hi_cnt;
                  if (hi_cnt > hi_max) hi_max = hi_cnt;
                  lo_cnt = 0;
                  so = resp_bit(mbits);
               end
               lo_cnt++;
            end
         end else if (!prev_cs) begin
            tail = lo_cnt;
         end
         prev_cs   = cs_n;
         prev_sclk = sclk;
      end
   end

   // ---------------- helpers ----------------
   task automatic issue(input logic rd, input logic bu, input logic [5:0] a,
                        input int len, input logic pd);
      @(negedge clk);
      cmd_read  = rd;
      cmd_burst = bu;
      cmd_addr  = a;
      cmd_len   = 6'(len);
      cmd_pwrdn = pd;
      cmd_valid = 1'b1;
      rd_n      = 0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9 busy after accept", int'(busy), 1);
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      chk("R9 done with CSn high", int'(cs_n), 1);
      @(negedge clk);
      chk("R9 done lasts one cycle", int'(done), 0);
   endtask

   task automatic check_frame(input logic rd, input logic bu, input logic [5:0] a,
                              input int len, input logic pd);
      chk("R1 header byte", int'(mo[0]), int'({rd, bu, a}));
      chk("R2 rising edge count", rises, 8 * (len + 1));
      for (int k = 1; k <= len; k++) begin
         if (rd) chk("R3 SI zero in read data", int'(mo[k]), 0);
         else    chk("R2 write byte", int'(mo[k]), int'(wr_pat ^ 8'(k - 1)));
      end
      if (rd) begin
         chk("R3 read byte count", rd_n, len);
         for (int j = 0; j < len; j++)
            chk("R3 read byte value", int'(rd_got[j]), int'(8'h3C ^ 8'(j + 1)));
      end
      chk("R4 status byte", int'(status), int'(stat_byte));
      chk("R5 shortest high phase", hi_min, B_HALF);
      chk("R5 longest high phase", hi_max, B_HALF);
      chk("R7 lead-in to first edge", lo_run[0], (pd ? B_PD : B_SETUP) + B_HALF);
      for (int k = 1; k < rises; k++) begin
         if (k % 8 == 0) chk("R6 inter-byte low", lo_run[k], B_GAP + B_HALF);
         else            chk("R5 low phase", lo_run[k], B_HALF);
      end
      chk("R8 tail before release", tail, B_HOLD);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk("R10 cs_n after reset", int'(cs_n), 1);
      chk("R10 sclk after reset", int'(sclk), 0);
      chk("R10 ready after reset", int'(cmd_ready), 1);
      chk("R10 busy after reset", int'(busy), 0);
      chk("R10 done after reset", int'(done), 0);
   endtask

   task automatic t_single_write();
      wr_pat = 8'h5A; stat_byte = 8'hA5;
      issue(1'b0, 1'b0, 6'h0A, 1, 1'b0);
      wait_done();
      check_frame(1'b0, 1'b0, 6'h0A, 1, 1'b0);
   endtask

   task automatic t_single_read();
      stat_byte = 8'h0F;
      issue(1'b1, 1'b0, 6'h31, 1, 1'b0);
      wait_done();
      check_frame(1'b1, 1'b0, 6'h31, 1, 1'b0);
   endtask

   task automatic t_burst_write();
      wr_pat = 8'hC3; stat_byte = 8'h81;
      issue(1'b0, 1'b1, 6'h3F, 4, 1'b0);
      wait_done();
      check_frame(1'b0, 1'b1, 6'h3F, 4, 1'b0);
   endtask

   task automatic t_burst_read();
      stat_byte = 8'h66;
      issue(1'b1, 1'b1, 6'h3F, 3, 1'b0);
      wait_done();
      check_frame(1'b1, 1'b1, 6'h3F, 3, 1'b0);
   endtask

   task automatic t_strobe();
      stat_byte = 8'h12;
      issue(1'b0, 1'b0, 6'h36, 0, 1'b0);
      wait_done();
      chk("R11 strobe is one byte", rises, 8);
      chk("R11 strobe header", int'(mo[0]), int'(8'h36));
      chk("R11 strobe tail", tail, B_HOLD);
      chk("R4 status from strobe", int'(status), int'(8'h12));
   endtask

   task automatic t_powerdown();
      wr_pat = 8'h99; stat_byte = 8'h40;
      issue(1'b0, 1'b0, 6'h02, 1, 1'b1);
      wait_done();
      check_frame(1'b0, 1'b0, 6'h02, 1, 1'b1);
   endtask

   task automatic t_busy_ignore();
      int f0;
      int ready_seen;
      wr_pat = 8'h11; stat_byte = 8'hA5;
      f0 = frames;
      issue(1'b0, 1'b0, 6'h05, 1, 1'b0);
      cmd_read  = 1'b1;
      cmd_burst = 1'b1;
      cmd_addr  = 6'h2A;
      cmd_len   = 6'd3;
      cmd_valid = 1'b1;
      ready_seen = 0;
      while (!done) begin
         if (cmd_ready) ready_seen++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk("R9 ready low while busy", ready_seen, 0);
      repeat (20) @(negedge clk);
      chk("R9 held command ignored: frames", frames - f0, 1);
      chk("R9 held command ignored: cs_n", int'(cs_n), 1);
      chk("R9 original header kept", int'(mo[0]), int'(8'h05));
      chk("R9 original length kept", rises, 16);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_single_write();
      t_single_read();
      t_burst_write();
      t_burst_read();
      t_strobe();
      t_powerdown();
      t_busy_ignore();
      finish_run();
   end

endmodule